// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable AND/OR/Invert array. It has 16 dedicated inputs, 48 product terms and 8 dedicated outputs. Each product term is the AND of one literal per input. For each input the literal is the true value, the complement, or nothing (don't care). Each output is the OR of any chosen subset of the 48 product terms, and that OR is then inverted. An active-low chip enable controls the outputs. A build-time parameter selects what a disabled output looks like: either a three-state style, with an output-enable vector beside the data vector, or an open-collector style, where the data is pulled to all ones.

The configuration is held in registers and written one row per clock through a synchronous word port. Rows 0 to 47 hold the AND-plane literals of one product term each. Rows 48 to 55 hold the OR-plane connections of outputs 0 to 7. Evaluation is purely combinational from the inputs and the current configuration. A written row therefore changes the outputs as soon as the clock edge that stores it has passed. The reset is asynchronous and active low, and its release is synchronised to the clock.

Top module: `sop_array`

## Requirements
- R1: While reset is held, and after it is released until the first write, every AND-plane link is intact and no term drives any output. With the chip enabled, `f_data` therefore reads 8'hFF and `f_oe` reads 8'hFF.
- R2: AND-plane row bits [2i+1:2i] set the literal of input i. 2'b01 uses the true value, 2'b10 uses the complement and 2'b11 is don't care. 2'b00 forces the product term to 0 whatever the inputs.
- R3: A product term whose 16 literals are all 2'b11 evaluates to 1 for every input pattern.
- R4: Output k equals the inverse of the OR of every product term p whose bit p is set in OR row k. Bit p of that row corresponds to product term p.
- R5: A cycle with `cfg_we` high and `cfg_row` equal to p (0..47) stores `cfg_data[31:0]` as the literals of term p. When `cfg_row` equals 48+k, the cycle stores `cfg_data[47:0]` as the connections of output k. The write changes nothing before the clock edge and is visible after it.
- R6: Rows 56 to 63 are ignored, and so is any cycle with `cfg_we` low. Neither changes any output.
- R7: In the three-state variant (`OPEN_DRAIN`=0), `f_oe` is 8'hFF while `ce_n` is low and 8'h00 while `ce_n` is high. `f_data` always carries the array's function.
- R8: In the open-collector variant (`OPEN_DRAIN`=1), `f_oe` is always 8'hFF. `f_data` carries the function while `ce_n` is low and is forced to 8'hFF while `ce_n` is high.
- R9: One product term can feed several outputs, and each output chooses its terms independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_row | input | 6 | Row address: 0..47 AND plane, 48..55 OR plane |
| cfg_data | input | 48 | Row data (AND rows use bits 31:0) |
| ce_n | input | 1 | Active-low chip enable |
| in_vec | input | 16 | Array inputs |
| f_data | output | 8 | Output data |
| f_oe | output | 8 | Output drive enable, one bit per output |

## Verification
The embedded assertions watch every cycle for three things. Each write to an AND or OR row lands in exactly the addressed row on the next edge. Writes with the strobe low or to an unmapped row leave both planes unchanged. An all-don't-care term is always true. They also hold the disabled-output shapes of both variants against `ce_n`. The full sum-of-products function can only be shown by the bench scenarios, whose reference model evaluates every input pattern and compares the outputs each clock. The same holds for the zero-forcing literal, the sharing of a term between outputs, the one-edge latency of a write and the non-aliasing of rows 56 to 63.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Two configuration bits per input per term: bit0 passes the true value,
  // bit1 passes the complement; both clear blocks the term entirely.
  typedef enum logic [1:0] {
    LIT_ZERO = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_DC   = 2'b11
  } lit_e;

  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    return (code[0] & x) | (code[1] & ~x);
  endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN  = 16,
  parameter int N_PT  = 48,
  parameter int ROW_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      wr_row,
  input  logic [2*N_IN-1:0]     wr_data,
  input  logic [N_IN-1:0]       in_vec,
  output logic [N_PT-1:0]       pt_vec
);
  import sop_pkg::*;

  localparam int LINK_W = 2 * N_IN;

  logic [N_PT-1:0][LINK_W-1:0] links_q, links_d;
  logic                        ld_en;

  // next-state
  always_comb begin
    links_d = links_q;
    ld_en   = 1'b0;
    for (int p = 0; p < N_PT; p++) begin
      if (wr_en && (wr_row == ROW_W'(p))) begin
        links_d[p] = wr_data;
        ld_en      = 1'b1;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      links_q <= '0;
    end else if (ld_en) begin
      links_q <= links_d;
    end
  end

  // evaluation
  always_comb begin
    for (int p = 0; p < N_PT; p++) begin
      pt_vec[p] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        pt_vec[p] = pt_vec[p] & lit_pass(links_q[p][2*i +: 2], in_vec[i]);
      end
    end
  end

  generate
    for (genvar p = 0; p < N_PT; p++) begin : g_row_chk
      // R5
      and_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row == ROW_W'(p)) |=> (links_q[p] == $past(wr_data)));
      // R3
      dc_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (links_q[p] == {N_IN{2'(LIT_DC)}}) |-> pt_vec[p]);
    end
  endgenerate

  // R6
  and_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_row >= ROW_W'(N_PT)) |=> $stable(links_q));

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_PT  = 48,
  parameter int N_OUT = 8,
  parameter int ROW_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      wr_row,
  input  logic [N_PT-1:0]       wr_data,
  input  logic [N_PT-1:0]       pt_vec,
  output logic [N_OUT-1:0]      or_vec
);

  logic [N_OUT-1:0][N_PT-1:0] conn_q, conn_d;
  logic                       ld_en;

  // next-state
  always_comb begin
    conn_d = conn_q;
    ld_en  = 1'b0;
    for (int k = 0; k < N_OUT; k++) begin
      if (wr_en && (wr_row == ROW_W'(N_PT + k))) begin
        conn_d[k] = wr_data;
        ld_en     = 1'b1;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= '0;
    end else if (ld_en) begin
      conn_q <= conn_d;
    end
  end

  // evaluation
  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      or_vec[k] = |(conn_q[k] & pt_vec);
    end
  end

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_col_chk
      // R5
      or_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row == ROW_W'(N_PT + k)) |=> (conn_q[k] == $past(wr_data)));
    end
  endgenerate

  // R6
  or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_row < ROW_W'(N_PT) || wr_row >= ROW_W'(N_PT + N_OUT))
      |=> $stable(conn_q));

endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
  parameter int N_OUT      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic [N_OUT-1:0] or_vec,
  output logic [N_OUT-1:0] f_data,
  output logic [N_OUT-1:0] f_oe
);

  generate
    if (OPEN_DRAIN) begin : g_oc
      always_comb begin
        f_oe   = '1;
        f_data = ce_n ? '1 : ~or_vec;
      end
      // R8
      oc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (&f_data));
      // R8
      oc_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&f_oe));
    end else begin : g_ts
      always_comb begin
        f_oe   = ce_n ? '0 : '1;
        f_data = ~or_vec;
      end
      // R7
      ts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (f_oe == '0));
      // R7
      ts_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (&f_oe));
    end
  endgenerate

endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN       = 16,
  parameter int N_PT       = 48,
  parameter int N_OUT      = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  localparam int ROW_W     = $clog2(N_PT + N_OUT),
  localparam int DATA_W    = (2 * N_IN > N_PT) ? 2 * N_IN : N_PT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              ce_n,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  f_data,
  output logic [N_OUT-1:0]  f_oe
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [N_PT-1:0]  pt_vec;
  logic [N_OUT-1:0] or_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sop_and_plane #(.N_IN(N_IN), .N_PT(N_PT), .ROW_W(ROW_W)) u_and (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_row  (cfg_row),
    .wr_data (cfg_data[2*N_IN-1:0]),
    .in_vec  (in_vec),
    .pt_vec  (pt_vec)
  );

  sop_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT), .ROW_W(ROW_W)) u_or (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_row  (cfg_row),
    .wr_data (cfg_data[N_PT-1:0]),
    .pt_vec  (pt_vec),
    .or_vec  (or_vec)
  );

  sop_out_stage #(.N_OUT(N_OUT), .OPEN_DRAIN(OPEN_DRAIN)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce_n    (ce_n),
    .or_vec  (or_vec),
    .f_data  (f_data),
    .f_oe    (f_oe)
  );

endmodule

// File: tb/tb_sop_array.sv
module tb_sop_array;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_row;
  logic [47:0] cfg_data;
  logic        ce_n;
  logic [15:0] in_vec;
  logic [7:0]  ts_data, ts_oe, oc_data, oc_oe;

  always #5 clk = ~clk;

  sop_array #(.OPEN_DRAIN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_data(cfg_data), .ce_n(ce_n), .in_vec(in_vec),
    .f_data(ts_data), .f_oe(ts_oe)
  );

  sop_array #(.OPEN_DRAIN(1'b1)) dut_oc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_data(cfg_data), .ce_n(ce_n), .in_vec(in_vec),
    .f_data(oc_data), .f_oe(oc_oe)
  );

  // behavioural reference state
  logic [31:0] and_m [48];
  logic [47:0] or_m  [8];
  int  tests = 0;
  int  fails = 0;
  bit  cmp_on = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 48; p++) and_m[p] <= '0;
      for (int k = 0; k < 8; k++)  or_m[k]  <= '0;
    end else if (cfg_we) begin
      if (int'(cfg_row) < 48)      and_m[cfg_row] <= cfg_data[31:0];
      else if (int'(cfg_row) < 56) or_m[int'(cfg_row) - 48] <= cfg_data;
    end
  end

  function automatic logic [7:0] model_fn(input logic [15:0] x);
    logic [47:0] term;
    logic [7:0]  res;
    for (int p = 0; p < 48; p++) begin
      term[p] = 1'b1;
      for (int i = 0; i < 16; i++) begin
        case (and_m[p][2*i +: 2])
          2'b00: term[p] = 1'b0;
          2'b01: if (!x[i]) term[p] = 1'b0;
          2'b10: if (x[i])  term[p] = 1'b0;
          default: ;
        endcase
      end
    end
    for (int k = 0; k < 8; k++) begin
      res[k] = 1'b1;
      for (int p = 0; p < 48; p++) begin
        if (or_m[k][p] && term[p]) res[k] = 1'b0;
      end
    end
    return res;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [7:0] e;
      e = model_fn(in_vec);
      chk("R4 three-state data", ts_data, e);
      chk("R7 three-state enable", ts_oe, ce_n ? 8'h00 : 8'hFF);
      chk("R8 open-collector data", oc_data, ce_n ? 8'hFF : e);
      chk("R8 open-collector enable", oc_oe, 8'hFF);
    end
  end

  task automatic wr(input int row, input logic [47:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_row = 6'(row); cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setin(input logic [15:0] x);
    @(posedge clk); #1;
    in_vec = x;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_row = '0; cfg_data = '0;
    ce_n = 1'b0; in_vec = 16'h1234;
    repeat (3) @(negedge clk);
    chk("R1 in reset data", ts_data, 8'hFF);
    chk("R1 in reset enable", ts_oe, 8'hFF);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;
    setin(16'hA5C3);
    chk("R1 after reset data", ts_data, 8'hFF);
    chk("R1 after reset oc data", oc_data, 8'hFF);

    // term0: in0 true, in1 complement, rest don't care
    wr(0, 48'h0000_FFFF_FFF9);
    setin(16'h0001);
    // R5: write to output0's OR row, visible only after the edge
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_row = 6'd48; cfg_data = 48'h1;
    @(negedge clk);
    chk("R5 before edge", {7'b0, ts_data[0]}, 8'h01);
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    chk("R5 after edge", {7'b0, ts_data[0]}, 8'h00);

    setin(16'h0003);
    chk("R2 complement literal blocks", {7'b0, ts_data[0]}, 8'h01);
    setin(16'h0000);
    chk("R2 true literal blocks", {7'b0, ts_data[0]}, 8'h01);
    setin(16'hFFF1);
    chk("R2 don't care literals", {7'b0, ts_data[0]}, 8'h00);

    // term1: all don't care, feeds output 7
    wr(1, 48'h0000_FFFF_FFFF);
    wr(55, 48'h2);
    setin(16'h0000);
    chk("R3 all-dc term, zeros", {7'b0, ts_data[7]}, 8'h00);
    setin(16'hBEEF);
    chk("R3 all-dc term, pattern", {7'b0, ts_data[7]}, 8'h00);

    // term2: input5 code 00 forces zero, feeds output 1
    wr(2, 48'h0000_FFFF_F3FF);
    wr(49, 48'h4);
    setin(16'hFFFF);
    chk("R2 zero literal, ones", {7'b0, ts_data[1]}, 8'h01);
    setin(16'h0000);
    chk("R2 zero literal, zeros", {7'b0, ts_data[1]}, 8'h01);

    // term3: input3 true, shared by outputs 2 and 3
    wr(3, 48'h0000_FFFF_FF7F);
    wr(50, 48'h8);
    wr(51, 48'h8);
    setin(16'h0008);
    chk("R9 shared term active", {6'b0, ts_data[3:2]}, 8'h00);
    setin(16'h0000);
    chk("R9 shared term idle", {6'b0, ts_data[3:2]}, 8'h03);
    wr(50, 48'h9);
    setin(16'h0001);
    chk("R4 OR of two terms", ts_data, 8'h7A);
    chk("R9 independent outputs", {6'b0, ts_data[3:2]}, 8'h02);

    // R6: strobe low and unmapped rows change nothing
    @(posedge clk); #1;
    cfg_row = 6'd48; cfg_data = 48'h0;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R6 strobe low ignored", ts_data, 8'h7A);
    wr(56, 48'h2);
    wr(60, 48'h2);
    wr(63, 48'hFFFF_FFFF_FFFF);
    setin(16'h0000);
    chk("R6 unmapped rows ignored", ts_data, 8'h7F);

    // chip enable
    setin(16'h0001);
    @(posedge clk); #1 ce_n = 1'b1;
    @(negedge clk);
    chk("R7 disabled enable", ts_oe, 8'h00);
    chk("R7 disabled data", ts_data, 8'h7A);
    chk("R8 disabled oc data", oc_data, 8'hFF);
    chk("R8 disabled oc enable", oc_oe, 8'hFF);
    @(posedge clk); #1 ce_n = 1'b0;
    @(negedge clk);
    chk("R8 enabled oc data", oc_data, 8'h7A);

    // random sweep: inputs, chip enable and writes, compared every clock
    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #1;
      in_vec = 16'($urandom);
      ce_n   = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) begin
        cfg_we   = 1'b1;
        cfg_row  = 6'($urandom_range(0, 63));
        cfg_data = 48'({$urandom, $urandom} | {$urandom, $urandom});
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(posedge clk); #1 cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    cmp_on = 1'b0;
    finish_run();
  end

endmodule